// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block resolves a translation miss by fetching one page-table entry from main memory. A caller pulses a start strobe with a virtual page number and an access kind. The walker first compares the page number against a table-length value and rejects out-of-range pages without touching memory. For a page in range, it reads the entry at the table base plus the page number scaled by the entry size. It then judges the entry's valid flag, reserved field and permission bits.

Every walk ends with a single-cycle completion strobe. The strobe carries a two-bit fault code, and on success it also carries the frame number and permission bits. A successful walk also raises a fill strobe toward the translation cache, with the page number, frame and permissions. Only one walk runs at a time. The memory side is a valid/ready request channel followed by a response of any latency.

Top module: `ptw_walker`

## Requirements
- R1: After reset, `busy`, `done`, `mem_req_valid` and `tlb_fill` are all low.
- R2: The entry is read from address `tbl_base + walk_vpn * 4`. While `mem_req_valid` is high and `mem_req_ready` is low, the request stays raised and `mem_req_addr` does not change.
- R3: If the page number is greater than or equal to `tbl_len`, the walk ends with fault code 01, and no memory request is issued for it.
- R4: An entry whose bit 0 (valid) is 0, or whose reserved bits 11:4 are not all zero, ends the walk with fault code 10.
- R5: Access kinds are encoded as follows: 00 read, 01 write, 10 execute, 11 reserved. Entry bits 1, 2 and 3 grant read, write and execute. An access whose kind is not granted, or whose kind is 11, ends the walk with fault code 11, unless an earlier rule already applies.
- R6: A walk with no violation ends with fault code 00, with `done_pfn` taken from entry bits 31:12 and `done_perm` taken from entry bits 3:1.
- R7: Each accepted start produces exactly one `done` pulse, one cycle wide.
- R8: `tlb_fill` is high exactly in the `done` cycle of a successful walk. In that cycle it carries the walk's page number, frame and permissions.
- R9: `walk_start` is ignored while `busy` is high. It does not start a second walk and does not alter the running one.
- R10: Each walk issues at most one request. The walker tolerates any ready stall and any response latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| walk_start | input | 1 | Start strobe, taken only when idle |
| walk_vpn | input | VPN_W | Page number to translate |
| walk_acc | input | 2 | Access kind (00 read, 01 write, 10 execute) |
| tbl_base | input | PA_W | Byte address of entry 0 |
| tbl_len | input | VPN_W+1 | Number of legal pages |
| busy | output | 1 | A walk is in progress |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | PA_W | Entry byte address |
| mem_rsp_valid | input | 1 | Entry data present |
| mem_rsp_data | input | 32 | Entry word |
| done | output | 1 | Walk completion pulse |
| done_fault | output | 2 | 00 ok, 01 length, 10 invalid, 11 protection |
| done_pfn | output | 20 | Frame number (valid on success) |
| done_perm | output | 3 | {execute, write, read} grants (valid on success) |
| tlb_fill | output | 1 | Translation cache write strobe |
| tlb_vpn | output | VPN_W | Page number to fill |
| tlb_pfn | output | 20 | Frame number to fill |
| tlb_perm | output | 3 | Permissions to fill |

## Verification
The hardest case to reach is a second start strobe that arrives while a walk is parked in a long memory stall. The bench drives it by raising the strobe with an out-of-range page number just after a legal walk has started. A correct design must then report only the original page, with exactly one completion. A further difficult case is an address that changes while ready is withheld. The memory model holds ready low for a programmed number of cycles and compares the address on every stalled cycle. The model also varies the response latency, including a zero-cycle latency.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  localparam int PTE_W         = 32;
  localparam int PTE_VALID_BIT = 0;
  localparam int PTE_PERM_LSB  = 1;
  localparam int PTE_PERM_W    = 3;
  localparam int PTE_PFN_LSB   = 12;
  localparam int PTE_PFN_W     = PTE_W - PTE_PFN_LSB;
  localparam int PTE_RSV_LSB   = PTE_PERM_LSB + PTE_PERM_W;

  localparam logic [1:0] ACC_READ  = 2'b00;
  localparam logic [1:0] ACC_WRITE = 2'b01;
  localparam logic [1:0] ACC_EXEC  = 2'b10;

  typedef enum logic [1:0] {
    FLT_NONE    = 2'b00,
    FLT_LEN     = 2'b01,
    FLT_INVALID = 2'b10,
    FLT_PROT    = 2'b11
  } ptw_fault_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BOUND,
    ST_ISSUE,
    ST_AWAIT,
    ST_JUDGE,
    ST_REPORT
  } ptw_state_e;

endpackage

// File: rtl/ptw_bounds.sv
module ptw_bounds #(
  parameter int VPN_W       = 20,
  parameter int PA_W        = 32,
  parameter int ENTRY_BYTES = 4
) (
  input  logic [VPN_W-1:0] vpn,
  input  logic [VPN_W:0]   len,
  input  logic [PA_W-1:0]  base,
  output logic             out_of_range,
  output logic [PA_W-1:0]  entry_addr
);

  localparam int OFF_SH = $clog2(ENTRY_BYTES);

  always_comb begin
    out_of_range = ({1'b0, vpn} >= len);
    entry_addr   = base + (PA_W'(vpn) << OFF_SH);
  end

endmodule

// File: rtl/ptw_entry_check.sv
module ptw_entry_check
  import ptw_pkg::*;
(
  input  logic [PTE_W-1:0]      pte,
  input  logic [1:0]            acc,
  output ptw_fault_e            fault,
  output logic [PTE_PFN_W-1:0]  pfn,
  output logic [PTE_PERM_W-1:0] perm
);

  logic granted;
  logic rsv_dirty;

  always_comb begin
    pfn       = pte[PTE_W-1:PTE_PFN_LSB];
    perm      = pte[PTE_RSV_LSB-1:PTE_PERM_LSB];
    rsv_dirty = |pte[PTE_PFN_LSB-1:PTE_RSV_LSB];
    unique case (acc)
      ACC_READ:  granted = perm[0];
      ACC_WRITE: granted = perm[1];
      ACC_EXEC:  granted = perm[2];
      default:   granted = 1'b0;
    endcase
    if (!pte[PTE_VALID_BIT] || rsv_dirty) fault = FLT_INVALID;
    else if (!granted)                     fault = FLT_PROT;
    else                                   fault = FLT_NONE;
  end

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int VPN_W       = 20,
  parameter int PA_W        = 32,
  parameter int ENTRY_BYTES = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  walk_start,
  input  logic [VPN_W-1:0]      walk_vpn,
  input  logic [1:0]            walk_acc,
  input  logic [PA_W-1:0]       tbl_base,
  input  logic [VPN_W:0]        tbl_len,
  output logic                  busy,
  output logic                  mem_req_valid,
  input  logic                  mem_req_ready,
  output logic [PA_W-1:0]       mem_req_addr,
  input  logic                  mem_rsp_valid,
  input  logic [PTE_W-1:0]      mem_rsp_data,
  output logic                  done,
  output logic [1:0]            done_fault,
  output logic [PTE_PFN_W-1:0]  done_pfn,
  output logic [PTE_PERM_W-1:0] done_perm,
  output logic                  tlb_fill,
  output logic [VPN_W-1:0]      tlb_vpn,
  output logic [PTE_PFN_W-1:0]  tlb_pfn,
  output logic [PTE_PERM_W-1:0] tlb_perm
);

  ptw_state_e state_q, state_d;

  logic [VPN_W-1:0]      vpn_q;
  logic [1:0]            acc_q;
  logic [PA_W-1:0]       addr_q;
  logic [PTE_W-1:0]      pte_q;
  ptw_fault_e            fault_q, fault_d;
  logic [PTE_PFN_W-1:0]  pfn_q, pfn_d;
  logic [PTE_PERM_W-1:0] perm_q, perm_d;

  logic                  oor;
  logic [PA_W-1:0]       entry_addr;
  ptw_fault_e            chk_fault;
  logic [PTE_PFN_W-1:0]  chk_pfn;
  logic [PTE_PERM_W-1:0] chk_perm;

  logic take_en, addr_en, pte_en, res_en;

  ptw_bounds #(
    .VPN_W(VPN_W), .PA_W(PA_W), .ENTRY_BYTES(ENTRY_BYTES)
  ) u_bounds (
    .vpn(vpn_q), .len(tbl_len), .base(tbl_base),
    .out_of_range(oor), .entry_addr(entry_addr)
  );

  ptw_entry_check u_judge (
    .pte(pte_q), .acc(acc_q),
    .fault(chk_fault), .pfn(chk_pfn), .perm(chk_perm)
  );

  // next state and enables
  always_comb begin
    state_d = state_q;
    take_en = 1'b0;
    addr_en = 1'b0;
    pte_en  = 1'b0;
    res_en  = 1'b0;
    fault_d = chk_fault;
    pfn_d   = chk_pfn;
    perm_d  = chk_perm;
    unique case (state_q)
      ST_IDLE: if (walk_start) begin
        take_en = 1'b1;
        state_d = ST_BOUND;
      end
      ST_BOUND: if (oor) begin
        res_en  = 1'b1;
        fault_d = FLT_LEN;
        pfn_d   = '0;
        perm_d  = '0;
        state_d = ST_REPORT;
      end else begin
        addr_en = 1'b1;
        state_d = ST_ISSUE;
      end
      ST_ISSUE:  if (mem_req_ready) state_d = ST_AWAIT;
      ST_AWAIT:  if (mem_rsp_valid) begin
        pte_en  = 1'b1;
        state_d = ST_JUDGE;
      end
      ST_JUDGE: begin
        res_en  = 1'b1;
        state_d = ST_REPORT;
      end
      ST_REPORT: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk) begin
    if (take_en) begin
      vpn_q <= walk_vpn;
      acc_q <= walk_acc;
    end
    if (addr_en) addr_q <= entry_addr;
    if (pte_en)  pte_q  <= mem_rsp_data;
    if (res_en) begin
      fault_q <= fault_d;
      pfn_q   <= pfn_d;
      perm_q  <= perm_d;
    end
  end

  always_comb begin
    busy          = (state_q != ST_IDLE);
    mem_req_valid = (state_q == ST_ISSUE);
    mem_req_addr  = addr_q;
    done          = (state_q == ST_REPORT);
    done_fault    = fault_q;
    done_pfn      = pfn_q;
    done_perm     = perm_q;
    tlb_fill      = done && (fault_q == FLT_NONE);
    tlb_vpn       = vpn_q;
    tlb_pfn       = pfn_q;
    tlb_perm      = perm_q;
  end

endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
  parameter int PA_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [PA_W-1:0] mem_req_addr,
  input logic            done,
  input logic [1:0]      done_fault,
  input logic            tlb_fill
);

  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> (!busy && !done && !mem_req_valid && !tlb_fill));

  a_r2_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  a_r3_req_inside_walk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> busy);

  a_r7_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_fill_on_success: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_fill |-> (done && done_fault == 2'b00));

  a_r10_single_request: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

endmodule

bind ptw_walker ptw_walker_chk #(.PA_W(PA_W)) u_chk (.*);

// File: tb/ptw_walker_bench.sv
module ptw_walker_bench;

  localparam logic [31:0] BASE = 32'h0001_0000;

  typedef struct {
    logic [19:0] vpn;
    logic [1:0]  fault;
    logic [19:0] pfn;
    logic [2:0]  perm;
    int          reqs;
  } item_t;

  logic        clk, rst_n;
  logic        walk_start;
  logic [19:0] walk_vpn;
  logic [1:0]  walk_acc;
  logic [31:0] tbl_base;
  logic [20:0] tbl_len;
  logic        busy, mem_req_valid, mem_req_ready, mem_rsp_valid;
  logic [31:0] mem_req_addr, mem_rsp_data;
  logic        done, tlb_fill;
  logic [1:0]  done_fault;
  logic [19:0] done_pfn, tlb_vpn, tlb_pfn;
  logic [2:0]  done_perm, tlb_perm;

  int n_chk, n_bad;
  int reqs_seen, stall_cfg, lat_cfg;
  logic [31:0] exp_addr;
  logic [31:0] pt [64];
  item_t sb_q [$];
  bit prev_done;

  ptw_walker u_ptw_walker (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  function automatic logic [31:0] mk_pte(input logic [19:0] pfn, input logic [2:0] perm, input bit v);
    return {pfn, 8'h00, perm, v};
  endfunction

  // memory model: stalls ready, checks address, returns entry after latency
  initial begin
    mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    forever begin
      @(negedge clk);
      if (mem_req_valid) begin
        logic [31:0] a0;
        a0 = mem_req_addr;
        chk(a0 == exp_addr, "R2 entry address", a0, exp_addr);
        for (int s = 0; s < stall_cfg; s++) begin
          @(negedge clk);
          chk(mem_req_valid && mem_req_addr == a0, "R2 held while stalled", mem_req_addr, a0);
        end
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        reqs_seen++;
        for (int l = 0; l < lat_cfg; l++) @(negedge clk);
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = pt[6'((a0 - BASE) >> 2)];
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
      end
    end
  end

  // scoreboard monitor
  initial begin
    prev_done = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (prev_done && done) chk(1'b0, "R7 done wider than one cycle", 1, 0);
        if (done) begin
          if (sb_q.size() == 0) begin
            chk(1'b0, "R7/R9 unexpected completion", tlb_vpn, 0);
          end else begin
            item_t e;
            e = sb_q.pop_front();
            chk(done_fault == e.fault, "R3/R4/R5/R6 fault code", done_fault, e.fault);
            chk(reqs_seen == e.reqs, "R3/R10 request count", reqs_seen, e.reqs);
            chk(tlb_fill == (e.fault == 2'b00), "R8 fill strobe", tlb_fill, e.fault == 2'b00);
            if (e.fault == 2'b00) begin
              chk(done_pfn == e.pfn && done_perm == e.perm, "R6 frame and perms",
                  {done_pfn, done_perm}, {e.pfn, e.perm});
              chk(tlb_vpn == e.vpn && tlb_pfn == e.pfn && tlb_perm == e.perm, "R8 fill payload",
                  {tlb_vpn, tlb_pfn, tlb_perm}, {e.vpn, e.pfn, e.perm});
            end
          end
        end
        prev_done = done;
      end
    end
  end

  task automatic walk(input logic [19:0] vpn, input logic [1:0] acc, input logic [20:0] len,
                      input logic [31:0] pte, input int stall, input int lat, input bit poke);
    item_t it;
    logic  granted;
    tbl_len   = len;
    stall_cfg = stall;
    lat_cfg   = lat;
    exp_addr  = BASE + {10'd0, vpn, 2'b00};
    pt[vpn[5:0]] = pte;
    granted = (acc == 2'b00) ? pte[1] : (acc == 2'b01) ? pte[2] : (acc == 2'b10) ? pte[3] : 1'b0;
    it.vpn  = vpn;
    it.pfn  = pte[31:12];
    it.perm = pte[3:1];
    if ({1'b0, vpn} >= len)                it.fault = 2'b01;
    else if (!pte[0] || pte[11:4] != 8'h0) it.fault = 2'b10;
    else if (!granted)                     it.fault = 2'b11;
    else                                   it.fault = 2'b00;
    it.reqs = (it.fault == 2'b01) ? 0 : 1;
    sb_q.push_back(it);
    reqs_seen = 0;
    walk_vpn = vpn; walk_acc = acc; walk_start = 1'b1;
    @(negedge clk);
    walk_start = 1'b0;
    if (poke) begin
      // R9: a second start during the walk must be ignored
      walk_vpn = 20'hFFFFF; walk_acc = 2'b11; walk_start = 1'b1;
      @(negedge clk);
      walk_start = 1'b0;
    end
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    report();
  end

  initial begin
    logic [15:0] lf;
    n_chk = 0; n_bad = 0; reqs_seen = 0; stall_cfg = 0; lat_cfg = 0;
    exp_addr = BASE;
    for (int i = 0; i < 64; i++) pt[i] = '0;
    rst_n = 1'b0; walk_start = 1'b0; walk_vpn = '0; walk_acc = '0;
    tbl_base = BASE; tbl_len = 21'd40;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_req_valid && !tlb_fill, "R1 outputs in reset",
        {busy, done, mem_req_valid, tlb_fill}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !mem_req_valid && !tlb_fill, "R1 outputs after release",
        {busy, done, mem_req_valid, tlb_fill}, 0);

    walk(20'd3,  2'b00, 21'd40, mk_pte(20'hABCDE, 3'b001, 1'b1), 0, 0, 1'b0); // R6 read ok
    walk(20'd4,  2'b01, 21'd40, mk_pte(20'h11111, 3'b001, 1'b1), 1, 2, 1'b0); // R5 write denied
    walk(20'd5,  2'b00, 21'd40, mk_pte(20'h22222, 3'b111, 1'b0), 0, 1, 1'b0); // R4 invalid
    walk(20'd6,  2'b00, 21'd40, mk_pte(20'h33333, 3'b111, 1'b1) | 32'h0000_0100, 0, 0, 1'b0); // R4 reserved
    walk(20'd40, 2'b00, 21'd40, mk_pte(20'h44444, 3'b111, 1'b1), 0, 0, 1'b0); // R3 vpn == len
    walk(20'd39, 2'b01, 21'd40, mk_pte(20'h55555, 3'b010, 1'b1), 2, 0, 1'b0); // R6 vpn == len-1
    walk(20'd7,  2'b10, 21'd40, mk_pte(20'h66666, 3'b100, 1'b1), 0, 0, 1'b0); // R6 execute ok
    walk(20'd8,  2'b11, 21'd40, mk_pte(20'h77777, 3'b111, 1'b1), 0, 0, 1'b0); // R5 reserved kind
    walk(20'hFFFFF, 2'b00, 21'd40, mk_pte(20'h0, 3'b111, 1'b1), 0, 0, 1'b0); // R3 far out of range
    walk(20'd0,  2'b00, 21'd0,  mk_pte(20'h88888, 3'b111, 1'b1), 0, 0, 1'b0); // R3 empty table
    walk(20'd9,  2'b00, 21'd40, mk_pte(20'h99999, 3'b011, 1'b1), 7, 9, 1'b1); // R9 poke, R10 long stall
    walk(20'd10, 2'b10, 21'd40, mk_pte(20'hAAAAA, 3'b011, 1'b0), 3, 0, 1'b1); // R4 beats R5, R9

    lf = 16'hACE1;
    for (int k = 0; k < 24; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      walk({14'd0, lf[5:0]}, lf[7:6], 21'd48,
           mk_pte({4'h0, lf}, lf[10:8], lf[11]), int'(lf[13:12]), int'(lf[15:14]), lf[2]);
    end

    repeat (4) @(negedge clk);
    chk(sb_q.size() == 0, "R7 every start completed", sb_q.size(), 0);
    report();
  end

endmodule